// File: doc/BRIEF.md
# Operator Precedence Expression Reducer

This block takes an infix expression as a stream of tokens and returns its value. The expression holds up to `N_MAX` unsigned numbers and the operators between them. The operators are add, subtract, bitwise AND, bitwise OR and greater-than compare. Tokens arrive at most one per clock with a valid strobe. A last flag on the final number closes the expression.

The numbers and operators go into two separate register arrays. A controller then makes three passes over the operator array, one entry per cycle. The first pass folds every compare, the second folds every AND and OR, and the third folds every add and subtract. Each fold writes its value into the left number of its pair. The entries after it then slide down one slot per cycle, so there is no unrolled search. The arithmetic runs through an ALU built from narrow slices joined by a carry chain. The value of the expression appears with a one-cycle done strobe.

Top module: `prec_reducer`

## Requirements
- R1: During and right after a synchronous active-low reset, `busy` and `res_valid` are 0 and `res_data` is 0.
- R2: Tokens alternate, starting and ending with a number. A number token has `tok_is_op`=0 and its value on `tok_val`. An operator token has `tok_is_op`=1 and its code on `tok_val[2:0]`: 0 add, 1 subtract, 2 AND, 3 OR, 4 compare. Compare gives 1 when the left operand is greater than the right as unsigned values, and 0 otherwise. Codes 5 to 7 act as add.
- R3: Compare binds tightest, AND and OR come next, and add and subtract bind loosest.
- R4: Operators of the same precedence level are applied left to right.
- R5: Add and subtract wrap modulo 2^DATA_W.
- R6: An expression of one number returns that number. An expression that stored no number returns 0.
- R7: Number tokens beyond `N_MAX` and operator tokens beyond `N_MAX`-1 are dropped. The stored prefix is what gets evaluated.
- R8: A token accepted with `tok_last`=1 ends loading, and `busy` is 1 from the next cycle until the result has been presented. Tokens offered while `busy` is 1 are ignored.
- R9: `res_valid` is a one-cycle pulse. `res_data` carries the result in that cycle and holds it until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_valid | input | 1 | A token is offered this cycle |
| tok_is_op | input | 1 | 1: operator token, 0: number token |
| tok_val | input | DATA_W | Number value, or operator code in bits 2:0 |
| tok_last | input | 1 | Offered token closes the expression |
| busy | output | 1 | Reducing. Tokens are ignored |
| res_valid | output | 1 | One-cycle strobe with the result |
| res_data | output | DATA_W | Value of the last expression |

## Verification
The bench checks mixed-precedence chains in which a wrong order of folding gives a visibly different number. Examples are an AND inside an add chain, and an OR followed by an AND where grouping the AND first gives a different value. It drives a full-capacity expression that needs several folds and slides, where a slide with a wrong stop index would drop or repeat an operand. It checks wrap-around on subtract and add, and an unsigned compare at the sign boundary. It sends tokens past capacity, which a design without bounds checks would store or alias. It sends junk tokens while the block is busy, which a design that keeps loading would fold into the result. Last, it sends a single number and an expression with no number at all, where a design that reduces anyway would return stale data.

// File: rtl/prec_reducer_pkg.sv
// Package: operator codes, controller states and the precedence rank
// shared by the reducer modules.
package prec_reducer_pkg;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_AND = 3'd2;
    localparam logic [2:0] OP_OR  = 3'd3;
    localparam logic [2:0] OP_CMP = 3'd4;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_SCAN,
        ST_SHIFT,
        ST_DONE
    } rdx_state_e;

    // Pass number in which an operator is folded: 0 first, 2 last.
    function automatic logic [1:0] op_rank(input logic [2:0] code);
        case (code)
            OP_CMP:        return 2'd0;
            OP_AND, OP_OR: return 2'd1;
            default:       return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/rdx_alu.sv
// Combinational ALU for one fold.
// Add and subtract are built from W/SLICE_W slices joined by a ripple carry.
// Subtract inverts b and sets the first carry.
// Assumes W is a multiple of SLICE_W. Codes 5..7 act as add.
module rdx_alu
    import prec_reducer_pkg::*;
#(
    parameter int W       = 16,
    parameter int SLICE_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] y
);
    localparam int NS = W / SLICE_W;

    logic          sub_mode;
    logic [W-1:0]  b_x;
    logic [W-1:0]  sum;
    logic [NS-1:0] cy;

    assign sub_mode = (op == OP_SUB);
    assign b_x      = sub_mode ? ~b : b;
    assign cy[0]    = sub_mode;

    for (genvar s = 0; s < NS; s++) begin : g_slice
        if (s == NS - 1) begin : g_top
            // Top slice: its carry out is the wrap-around and is dropped.
            assign sum[s*SLICE_W +: SLICE_W] = a[s*SLICE_W +: SLICE_W]
                + b_x[s*SLICE_W +: SLICE_W] + {{(SLICE_W-1){1'b0}}, cy[s]};
        end else begin : g_mid
            logic [SLICE_W:0] part;
            // Inner slice: adds with carry in and passes its carry up.
            assign part = {1'b0, a[s*SLICE_W +: SLICE_W]}
                + {1'b0, b_x[s*SLICE_W +: SLICE_W]} + {{SLICE_W{1'b0}}, cy[s]};
            assign sum[s*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            assign cy[s+1] = part[SLICE_W];
        end
    end

    // Picks the operation result.
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_CMP:  y = {{(W-1){1'b0}}, (a > b)};
            default: y = sum;
        endcase
    end

    // Checks the sliced chain against a full-width subtract.
    always_comb begin
        if (op == OP_SUB) begin
            // R5
            diff_wrap_chk: assert (sum == W'(a - b));
        end
    end

endmodule

// File: rtl/rdx_store.sv
// Number and operator arrays.
// Load writes an entry by index. A fold overwrites one number.
// A slide step moves entry k+2 of the numbers to k+1 and entry k+1 of the
// operators to k.
// Assumes N >= 2 and a power of two for the read index.
module rdx_store #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int CW = $clog2(N + 1),
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_num_en,
    input  logic [CW-1:0] ld_num_idx,
    input  logic [W-1:0]  ld_num,
    input  logic          ld_op_en,
    input  logic [CW-1:0] ld_op_idx,
    input  logic [2:0]    ld_op,
    input  logic          red_en,
    input  logic [CW-1:0] red_idx,
    input  logic [W-1:0]  red_val,
    input  logic          sh_en,
    input  logic [CW-1:0] sh_idx,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [2:0]    rd_op,
    output logic [W-1:0]  head
);
    logic [W-1:0] num_q [N];
    logic [2:0]   op_q  [N];
    logic [N-1:0][W-1:0] num_up;
    logic [N-1:0][2:0]   op_up;

    for (genvar j = 0; j < N; j++) begin : g_up
        if (j < N - 1) begin : g_mid
            // Right-hand neighbour of entry j.
            assign num_up[j] = num_q[j+1];
            assign op_up[j]  = op_q[j+1];
        end else begin : g_end
            assign num_up[j] = '0;
            assign op_up[j]  = '0;
        end
    end

    // Writes each entry from load, fold or slide, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) begin
                num_q[j] <= '0;
                op_q[j]  <= '0;
            end
        end else begin
            for (int j = 0; j < N; j++) begin
                if (ld_num_en && ld_num_idx == CW'(j))
                    num_q[j] <= ld_num;
                else if (red_en && red_idx == CW'(j))
                    num_q[j] <= red_val;
                else if (sh_en && (sh_idx + CW'(1)) == CW'(j))
                    num_q[j] <= num_up[j];

                if (ld_op_en && ld_op_idx == CW'(j))
                    op_q[j] <= ld_op;
                else if (sh_en && sh_idx == CW'(j))
                    op_q[j] <= op_up[j];
            end
        end
    end

    assign rd_a  = num_q[rd_idx];
    assign rd_b  = num_up[rd_idx];
    assign rd_op = op_q[rd_idx];
    assign head  = num_q[0];

endmodule

// File: rtl/rdx_ctrl.sv
// Sequencer for the reducer.
// It accepts tokens until the last flag, then scans the operators once per
// precedence rank. On a match it folds the pair and slides the remaining
// entries down one per cycle.
// Assumes well-formed alternating tokens (see the requirements on tokens).
module rdx_ctrl
    import prec_reducer_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int CW = $clog2(N + 1),
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_valid,
    input  logic          tok_is_op,
    input  logic          tok_last,
    input  logic [2:0]    rd_op,
    input  logic [W-1:0]  head,
    output logic          ld_num_en,
    output logic [CW-1:0] ld_num_idx,
    output logic          ld_op_en,
    output logic [CW-1:0] ld_op_idx,
    output logic          red_en,
    output logic [CW-1:0] red_idx,
    output logic          sh_en,
    output logic [CW-1:0] sh_idx,
    output logic [IW-1:0] rd_idx,
    output logic          busy,
    output logic          res_valid,
    output logic [W-1:0]  res_data
);
    rdx_state_e    state_q;
    logic [CW-1:0] n_q, o_q, idx_q, k_q;
    logic [1:0]    pass_q;
    logic [W-1:0]  res_q;
    logic          accept, at_end, hit;

    // Load strobes, with the capacity limits.
    assign accept     = (state_q == ST_LOAD) && tok_valid;
    assign ld_num_en  = accept && !tok_is_op && (n_q < CW'(N));
    assign ld_op_en   = accept && tok_is_op && (o_q < CW'(N - 1));
    assign ld_num_idx = n_q;
    assign ld_op_idx  = o_q;

    // Scan decode: past the last operator, or an operator of this pass.
    assign at_end  = (idx_q + CW'(1)) >= n_q;
    assign hit     = (state_q == ST_SCAN) && !at_end && (op_rank(rd_op) == pass_q);
    assign red_en  = hit;
    assign red_idx = idx_q;
    assign sh_en   = (state_q == ST_SHIFT);
    assign sh_idx  = k_q;
    assign rd_idx  = idx_q[IW-1:0];

    assign busy      = (state_q != ST_LOAD);
    assign res_valid = (state_q == ST_DONE);
    assign res_data  = res_q;

    // Sequence: load, scan passes, slides, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            n_q     <= '0;
            o_q     <= '0;
            idx_q   <= '0;
            k_q     <= '0;
            pass_q  <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (ld_num_en) n_q <= n_q + CW'(1);
                    if (ld_op_en)  o_q <= o_q + CW'(1);
                    if (accept && tok_last) begin
                        state_q <= ST_SCAN;
                        idx_q   <= '0;
                        pass_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (at_end) begin
                        idx_q <= '0;
                        if (pass_q == 2'd2) begin
                            res_q   <= (n_q == '0) ? '0 : head;
                            state_q <= ST_DONE;
                        end else begin
                            pass_q <= pass_q + 2'd1;
                        end
                    end else if (hit) begin
                        if ((idx_q + CW'(2)) == n_q) begin
                            n_q <= n_q - CW'(1);
                        end else begin
                            k_q     <= idx_q;
                            state_q <= ST_SHIFT;
                        end
                    end else begin
                        idx_q <= idx_q + CW'(1);
                    end
                end
                ST_SHIFT: begin
                    if ((k_q + CW'(3)) == n_q) begin
                        n_q     <= n_q - CW'(1);
                        state_q <= ST_SCAN;
                    end else begin
                        k_q <= k_q + CW'(1);
                    end
                end
                default: begin
                    n_q     <= '0;
                    o_q     <= '0;
                    state_q <= ST_LOAD;
                end
            endcase
        end
    end

    // R3
    rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !at_end) |-> (op_rank(rd_op) >= pass_q));

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_q));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tok_valid && tok_last));

    // R7
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q <= CW'(N)) && (o_q <= CW'(N - 1)));

endmodule

// File: rtl/prec_reducer.sv
// Top level: token-fed precedence reducer.
// It wires the sequencer, the operand arrays and the sliced ALU together.
// Assumes N_MAX >= 2 and a power of two, and DATA_W a multiple of SLICE_W.
module prec_reducer #(
    parameter int N_MAX   = 8,
    parameter int DATA_W  = 16,
    parameter int SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic              tok_is_op,
    input  logic [DATA_W-1:0] tok_val,
    input  logic              tok_last,
    output logic              busy,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    localparam int CW = $clog2(N_MAX + 1);
    localparam int IW = $clog2(N_MAX);

    logic              ld_num_en, ld_op_en, red_en, sh_en;
    logic [CW-1:0]     ld_num_idx, ld_op_idx, red_idx, sh_idx;
    logic [IW-1:0]     rd_idx;
    logic [DATA_W-1:0] rd_a, rd_b, head, alu_y;
    logic [2:0]        rd_op;

    rdx_ctrl #(.N(N_MAX), .W(DATA_W), .CW(CW), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_is_op  (tok_is_op),
        .tok_last   (tok_last),
        .rd_op      (rd_op),
        .head       (head),
        .ld_num_en  (ld_num_en),
        .ld_num_idx (ld_num_idx),
        .ld_op_en   (ld_op_en),
        .ld_op_idx  (ld_op_idx),
        .red_en     (red_en),
        .red_idx    (red_idx),
        .sh_en      (sh_en),
        .sh_idx     (sh_idx),
        .rd_idx     (rd_idx),
        .busy       (busy),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );

    rdx_store #(.N(N_MAX), .W(DATA_W), .CW(CW), .IW(IW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_num_en  (ld_num_en),
        .ld_num_idx (ld_num_idx),
        .ld_num     (tok_val),
        .ld_op_en   (ld_op_en),
        .ld_op_idx  (ld_op_idx),
        .ld_op      (tok_val[2:0]),
        .red_en     (red_en),
        .red_idx    (red_idx),
        .red_val    (alu_y),
        .sh_en      (sh_en),
        .sh_idx     (sh_idx),
        .rd_idx     (rd_idx),
        .rd_a       (rd_a),
        .rd_b       (rd_b),
        .rd_op      (rd_op),
        .head       (head)
    );

    rdx_alu #(.W(DATA_W), .SLICE_W(SLICE_W)) u_alu (
        .a  (rd_a),
        .b  (rd_b),
        .op (rd_op),
        .y  (alu_y)
    );

endmodule

// File: tb/test_prec_reducer.sv
// Bench: a vector table walked by one loop, then directed reset and corner tests.
module test_prec_reducer;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tok_valid = 1'b0, tok_is_op = 1'b0, tok_last = 1'b0;
    logic [W-1:0] tok_val = '0;
    logic         busy, res_valid;
    logic [W-1:0] res_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    prec_reducer #(.N_MAX(N), .DATA_W(W), .SLICE_W(8)) i_prec_reducer (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_is_op(tok_is_op),
        .tok_val(tok_val), .tok_last(tok_last), .busy(busy),
        .res_valid(res_valid), .res_data(res_data)
    );

    // Operator codes: 0 add, 1 sub, 2 and, 3 or, 4 compare, 5..7 as add.
    localparam int V_CNT [NV] = '{4, 3, 3, 2, 2, 3, 2, 8, 1, 2, 2};
    localparam logic [W-1:0] V_NUM [NV][8] = '{
        '{16'd123, 16'd50, 16'd33, 16'd34, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'd10, 16'd3, 16'd2, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'd7, 16'd5, 16'd3, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'd1, 16'd2, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'hFFFF, 16'd2, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'h0F0F, 16'h00F0, 16'h0F00, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'd9, 16'd9, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'd100, 16'd6, 16'd2, 16'd3, 16'd20, 16'd1, 16'd5, 16'd8},
        '{16'hBEEF, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'd40, 16'd2, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{16'h8000, 16'h7FFF, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}
    };
    localparam logic [2:0] V_OP [NV][7] = '{
        '{3'd0, 3'd1, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd0, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd3, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd1, 3'd4, 3'd2, 3'd0, 3'd3, 3'd4, 3'd1},
        '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd6, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0}
    };
    localparam logic [W-1:0] V_EXP [NV] = '{16'd141, 16'd9, 16'd8, 16'hFFFF, 16'd1,
        16'h0F00, 16'd0, 16'd111, 16'hBEEF, 16'd42, 16'd1};

    function automatic string vec_req(input int v);
        case (v)
            0, 2, 7: return "R3 precedence";
            1, 5:    return "R4 left to right";
            3, 4:    return "R5 wrap";
            8:       return "R6 single number";
            default: return "R2 operator codes";
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one token for one cycle.
    task automatic send_tok(input logic is_op, input logic [W-1:0] v, input logic last);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_is_op = is_op;
        tok_val   = v;
        tok_last  = last;
    endtask

    // Stops driving, checks busy, waits for the strobe, then checks the hold.
    task automatic finish_wait(output logic [W-1:0] r);
        @(negedge clk);
        tok_valid = 1'b0;
        tok_last  = 1'b0;
        chk("R8 busy after last token", W'(busy), W'(1));
        r = '0;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (res_valid) break;
        end
        chk("R9 result strobe seen", W'(res_valid), W'(1));
        r = res_data;
        @(negedge clk);
        chk("R9 strobe lasts one cycle", W'(res_valid), W'(0));
        chk("R9 result held", res_data, r);
    endtask

    task automatic run_vector(input int v);
        logic [W-1:0] r;
        for (int i = 0; i < V_CNT[v]; i++) begin
            send_tok(1'b0, V_NUM[v][i], i == V_CNT[v] - 1);
            if (i < V_CNT[v] - 1) send_tok(1'b1, W'(V_OP[v][i]), 1'b0);
        end
        finish_wait(r);
        chk(vec_req(v), r, V_EXP[v]);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        repeat (5) @(negedge clk);
        // R1: state while reset is held.
        chk("R1 busy in reset", W'(busy), W'(0));
        chk("R1 res_valid in reset", W'(res_valid), W'(0));
        chk("R1 res_data in reset", res_data, W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", W'(busy), W'(0));
        chk("R1 res_data after reset", res_data, W'(0));

        for (int v = 0; v < NV; v++) run_vector(v);

        // R7: nine ones joined by add; only eight numbers fit.
        for (int i = 0; i < 9; i++) begin
            send_tok(1'b0, W'(1), i == 8);
            if (i < 8) send_tok(1'b1, W'(0), 1'b0);
        end
        finish_wait(r);
        chk("R7 capacity drop", r, W'(8));

        // R8: junk offered while busy must not enter the expression.
        send_tok(1'b0, W'(3), 1'b0);
        send_tok(1'b1, W'(0), 1'b0);
        send_tok(1'b0, W'(4), 1'b1);
        send_tok(1'b0, W'(1000), 1'b1);
        chk("R8 busy while junk offered", W'(busy), W'(1));
        send_tok(1'b1, W'(4), 1'b0);
        finish_wait(r);
        chk("R8 tokens ignored while busy", r, W'(7));
        send_tok(1'b0, W'(2), 1'b1);
        finish_wait(r);
        chk("R8 no leftover after busy", r, W'(2));

        // R6: an operator with the last flag and no number gives 0.
        send_tok(1'b1, W'(0), 1'b1);
        finish_wait(r);
        chk("R6 empty expression", r, W'(0));

        // R9: result stays put while idle.
        repeat (5) @(negedge clk);
        chk("R9 idle hold", res_data, W'(0));
        chk("R9 no strobe while idle", W'(res_valid), W'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule